// File: doc/BRIEF.md
# Variable-Length Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation converter. It decides when a conversion begins, walks a 12-bit approximation register from the most significant bit downward one bit per clock, and presents each trial code to an external comparator and DAC pair. It keeps or drops the bit under trial according to the comparator answer. When the walk ends it copies the finished word into a result register and drops its busy flag.

Each conversion can be short (8 resolved bits) or full (12 resolved bits). A length-select input is sampled once, at the moment the conversion starts, and is held for the rest of that conversion. A short conversion stops right after the trial for bit 3 has been set. Its low nibble therefore reads back as the fixed pattern 1000. A conversion is requested by a high-to-low transition on the convert strobe, which counts only while the device is enabled and selected.

Top module: `sar_seq_top`

## Requirements
- R1: A falling edge of `conv_n`, seen at a clock edge while `en`=1, `cs_n`=0 and `busy`=0, starts a conversion, and `busy` is 1 after that edge.
- R2: No conversion starts and `busy` stays 0 when `en`=0, when `cs_n`=1, or when `conv_n` has not fallen.
- R3: A falling edge of `conv_n` during a conversion is ignored: the conversion length and result are unchanged.
- R4: `short_sel` is captured at the start edge. Changes to it later have no effect on the running conversion.
- R5: With a captured `short_sel`=0, the result is the largest 12-bit code not above the comparator input, which for an ideal comparator equals the input code.
- R6: With a captured `short_sel`=1, result bits [11:4] are the resolved upper byte and bits [3:0] are 4'b1000.
- R7: `busy` stays high for exactly 13 clock cycles on a full conversion and 9 on a short one.
- R8: Bits are resolved MSB first. The first trial code after the start edge is 12'h800, and each later trial adds the next lower bit.
- R9: `result` changes only on the cycle in which `busy` falls. It holds its previous value throughout a conversion.
- R10: After a synchronous reset (`rst_n`=0), `busy`, `result` and `trial_code` are all 0, and a conversion in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_n | input | 1 | Convert strobe; a falling edge requests a conversion |
| en | input | 1 | Enable, active high |
| cs_n | input | 1 | Select, active low |
| short_sel | input | 1 | Length select: 1 gives 8 bits, 0 gives 12 bits, captured at start |
| cmp_ge | input | 1 | Comparator result: 1 when the input is at or above `trial_code` |
| trial_code | output | 12 | Code driven to the DAC for the current trial |
| busy | output | 1 | High while a conversion and its result capture are running |
| result | output | 12 | Last completed conversion word |

## Verification
The checker watches every cycle for the following:
- the start condition and its absence leading to the right `busy` value on the next cycle;
- the busy window lasting 9 or 13 cycles according to its own copy of the captured length;
- the first trial code being the MSB;
- the result moving only when `busy` falls;
- the short-conversion filler nibble.

Whether the resolved bits actually match the analog input can only be shown by the bench's scenarios, which close the loop through an ideal comparator model. The same holds for whether mid-conversion changes to the length select and extra strobes are harmless, and for whether reset abandons a running conversion.

// File: rtl/sar_pkg.sv
// Package: shared types for the successive-approximation sequencer.
// Assumes nothing beyond being compiled before the modules that use it.
package sar_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_STEP = 2'd1,
        PH_CAP  = 2'd2
    } sar_phase_t;
endpackage

// File: rtl/sar_start_gate.sv
// Start gate: turns a high-to-low transition of the convert strobe into a
// one-cycle start request. The request is qualified by enable, select and
// the idle state. Assumes conv_n is already synchronous to clk.
module sar_start_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_n,
    input  logic en,
    input  logic cs_n,
    input  logic busy,
    output logic start
);
    logic conv_q;

    // Remember the strobe level from the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) conv_q <= 1'b1;
        else        conv_q <= conv_n;
    end

    // A fall is accepted only while enabled, selected and idle.
    always_comb begin
        start = conv_q & ~conv_n & en & ~cs_n & ~busy;
    end
endmodule

// File: rtl/sar_bit_engine.sv
// Bit engine: owns the approximation register. On start it sets the MSB as
// the first trial. Each step then keeps or clears the bit under trial and
// sets the next lower one. It stops at bit 0, or at bit W-SW when the
// captured length select asks for a short conversion. One capture cycle
// follows the last step. Assumes cmp_ge answers for the code currently on
// trial within the same cycle.
module sar_bit_engine
    import sar_pkg::*;
#(
    parameter int W  = 12,
    parameter int SW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         short_sel,
    input  logic         cmp_ge,
    output logic [W-1:0] sar,
    output logic         busy,
    output logic         cap
);
    localparam int IW = $clog2(W);
    localparam logic [IW-1:0] TOP_IDX    = IW'(W - 1);
    localparam logic [IW-1:0] SHORT_LAST = IW'(W - SW);
    localparam logic [W-1:0]  MSB_ONLY   = W'(1) << (W - 1);

    sar_phase_t    phase;
    logic [IW-1:0] idx;
    logic          short_q;
    logic [W-1:0]  sar_next;
    logic          last_step;

    // Resolve the bit under trial and set the next one as the new trial.
    always_comb begin
        sar_next = sar;
        if (!cmp_ge) sar_next[idx] = 1'b0;
        if (idx != '0) sar_next[idx - IW'(1)] = 1'b1;
    end

    // The last step is bit 0 for a full conversion, bit W-SW for a short one.
    always_comb begin
        last_step = (idx == (short_q ? SHORT_LAST : '0));
    end

    // Sequence state: idle, one step per bit, then one capture cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            sar     <= '0;
            idx     <= '0;
            short_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        sar     <= MSB_ONLY;
                        idx     <= TOP_IDX;
                        short_q <= short_sel;
                        phase   <= PH_STEP;
                    end
                end
                PH_STEP: begin
                    sar <= sar_next;
                    if (idx != '0) idx <= idx - IW'(1);
                    if (last_step) phase <= PH_CAP;
                end
                PH_CAP:  phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Status decode from the phase register.
    always_comb begin
        busy = (phase != PH_IDLE);
        cap  = (phase == PH_CAP);
    end
endmodule

// File: rtl/sar_result_reg.sv
// Result register: loads the finished approximation word on the capture
// cycle and holds it otherwise. Assumes cap is high for one cycle per
// conversion.
module sar_result_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] word,
    output logic [W-1:0] result
);
    // Load only when a conversion completes.
    always_ff @(posedge clk) begin
        if (!rst_n)   result <= '0;
        else if (cap) result <= word;
    end
endmodule

// File: rtl/sar_seq_top.sv
// Top: variable-length successive-approximation sequencer. It joins the
// start gate, the bit engine and the result register. The comparator and
// DAC are outside; trial_code goes to the DAC and cmp_ge comes back.
module sar_seq_top #(
    parameter int W  = 12,
    parameter int SW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_n,
    input  logic         en,
    input  logic         cs_n,
    input  logic         short_sel,
    input  logic         cmp_ge,
    output logic [W-1:0] trial_code,
    output logic         busy,
    output logic [W-1:0] result
);
    logic start;
    logic cap;

    sar_start_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .conv_n (conv_n),
        .en     (en),
        .cs_n   (cs_n),
        .busy   (busy),
        .start  (start)
    );

    sar_bit_engine #(.W(W), .SW(SW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .short_sel (short_sel),
        .cmp_ge    (cmp_ge),
        .sar       (trial_code),
        .busy      (busy),
        .cap       (cap)
    );

    sar_result_reg #(.W(W)) u_result (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap),
        .word   (trial_code),
        .result (result)
    );
endmodule

// File: rtl/sar_seq_chk.sv
// Checker: cycle-level properties of the sequencer, observed from its ports.
// It keeps its own strobe history, length copy and busy-window counter.
module sar_seq_chk #(
    parameter int W  = 12,
    parameter int SW = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         conv_n,
    input logic         en,
    input logic         cs_n,
    input logic         short_sel,
    input logic [W-1:0] trial_code,
    input logic         busy,
    input logic [W-1:0] result
);
    localparam int CW = $clog2(W + 2) + 1;
    localparam logic [W-1:0]    MSB_ONLY = W'(1) << (W - 1);
    localparam logic [W-SW-1:0] FILLER   = (W - SW)'(1) << (W - SW - 1);

    logic          conv_c;
    logic          short_c;
    logic [CW-1:0] len_cnt;
    logic          go_c;

    // Independent start decode from the port view.
    always_comb go_c = conv_c & ~conv_n & en & ~cs_n & ~busy;

    // Track the strobe, the captured length and the busy window length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_c  <= 1'b1;
            short_c <= 1'b0;
            len_cnt <= '0;
        end else begin
            conv_c  <= conv_n;
            if (go_c) short_c <= short_sel;
            len_cnt <= busy ? len_cnt + CW'(1) : '0;
        end
    end

    // R1
    start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_c |=> busy);
    // R2
    no_spurious_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go_c) |=> !busy);
    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (len_cnt == (short_c ? CW'(SW + 1) : CW'(W + 1))));
    // R8
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (trial_code == MSB_ONLY));
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $fell(busy));
    // R6
    short_filler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && short_c) |-> (result[W-SW-1:0] == FILLER));
endmodule

bind sar_seq_top sar_seq_chk #(.W(W), .SW(SW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_n     (conv_n),
    .en         (en),
    .cs_n       (cs_n),
    .short_sel  (short_sel),
    .trial_code (trial_code),
    .busy       (busy),
    .result     (result)
);

// File: tb/sim_sar_seq_top.sv
`timescale 1ns/1ps
module sim_sar_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_n = 1'b1;
    logic        en = 1'b1;
    logic        cs_n = 1'b0;
    logic        short_sel = 1'b0;
    logic [11:0] vin = '0;
    logic        cmp_ge;
    logic [11:0] trial_code;
    logic        busy;
    logic [11:0] result;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    // Ideal comparator against the stimulus code.
    assign cmp_ge = (vin >= trial_code);

    sar_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .en(en), .cs_n(cs_n),
        .short_sel(short_sel), .cmp_ge(cmp_ge), .trial_code(trial_code),
        .busy(busy), .result(result)
    );

    // Fields: [24:13] input code, [12] short select, [11:0] expected result.
    localparam logic [24:0] VEC [10] = '{
        {12'hABC, 1'b0, 12'hABC},
        {12'hABC, 1'b1, 12'hAB8},
        {12'h000, 1'b0, 12'h000},
        {12'h000, 1'b1, 12'h008},
        {12'hFFF, 1'b0, 12'hFFF},
        {12'hFFF, 1'b1, 12'hFF8},
        {12'h800, 1'b0, 12'h800},
        {12'h7FF, 1'b1, 12'h7F8},
        {12'h123, 1'b0, 12'h123},
        {12'h5A7, 1'b1, 12'h5A8}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One conversion; 'extra' adds a second strobe fall while busy (R3).
    task automatic run_conv(input logic [11:0] v, input logic s,
                            input logic [11:0] exp, input bit extra);
        logic [11:0] prev;
        int cycles;
        bit hold_ok;
        @(negedge clk);
        vin = v; short_sel = s; en = 1'b1; cs_n = 1'b0; conv_n = 1'b0;
        prev = result;
        @(posedge clk); #1;
        chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
        chk(trial_code == 12'h800, "R8 first trial", int'(trial_code), 'h800);
        short_sel = ~s;   // R4: later change must not matter
        cycles = 0;
        hold_ok = 1'b1;
        while (busy && cycles < 100) begin
            if (extra && cycles == 1) conv_n = 1'b1;
            if (extra && cycles == 3) conv_n = 1'b0;   // R3: ignored fall
            @(posedge clk); #1;
            cycles++;
            if (busy && result != prev) hold_ok = 1'b0;
        end
        chk(hold_ok, "R9 result held during conversion", int'(hold_ok), 1);
        chk(cycles == (s ? 9 : 13), extra ? "R7 R3 busy length" : "R7 busy length",
            cycles, s ? 9 : 13);
        chk(result == exp, s ? "R6 R4 short result" : "R5 R4 full result",
            int'(result), int'(exp));
        conv_n = 1'b1;
        @(posedge clk); #1;
        chk(busy == 1'b0, "R3 no restart after conversion", int'(busy), 0);
    endtask

    // Blocked strobe: en/cs_n gate (R2).
    task automatic blocked(input logic e, input logic c);
        logic [11:0] prev;
        bit quiet;
        @(negedge clk);
        en = e; cs_n = c; conv_n = 1'b0;
        prev = result;
        quiet = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            if (busy) quiet = 1'b0;
        end
        chk(quiet, "R2 gated strobe starts nothing", int'(quiet), 1);
        chk(result == prev, "R2 result untouched", int'(result), int'(prev));
        conv_n = 1'b1; en = 1'b1; cs_n = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(busy == 1'b0, "R10 reset busy", int'(busy), 0);
        chk(result == 12'h000, "R10 reset result", int'(result), 0);
        chk(trial_code == 12'h000, "R10 reset trial", int'(trial_code), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(busy == 1'b0, "R2 idle without strobe", int'(busy), 0);

        for (int k = 0; k < 10; k++)
            run_conv(VEC[k][24:13], VEC[k][12], VEC[k][11:0], 1'b0);

        run_conv(12'h3C5, 1'b0, 12'h3C5, 1'b1);
        run_conv(12'h3C5, 1'b1, 12'h3C8, 1'b1);

        blocked(1'b0, 1'b0);
        blocked(1'b1, 1'b1);

        // R10: reset during a conversion abandons it.
        @(negedge clk);
        vin = 12'h456; short_sel = 1'b0; conv_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(busy == 1'b0, "R10 reset mid-conversion busy", int'(busy), 0);
        chk(result == 12'h000, "R10 reset mid-conversion result", int'(result), 0);
        @(negedge clk); rst_n = 1'b1; conv_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        run_conv(12'h9E1, 1'b1, 12'h9E8, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule